// File: doc/BRIEF.md
# Register-Driven Single-Line SPI Shift Engine

This block is an SPI master for short raw exchanges. Software loads up to six outgoing bytes into a transmit bank and writes the exchange length, counted in bits, to a length register. It then sets the go bit in the command register. The engine lowers chip select and clocks the bits out MSB-first on one data line in SPI mode 0. At the same time it shifts the incoming line into a ten-byte receive bank. When the exchange is over it releases chip select and clears the go bit, which software polls as a busy flag.

The transmit bank is read out in descending index order: index 5 goes first and index 0 goes last. Bits beyond the six loaded bytes go out as zero. The receive bank is one continuous shift register, so after an exchange of N bytes the first byte received sits at index N-1 and later bytes sit at lower indices. The register port uses a valid/ready request channel and a valid/ready read-response channel. A write produces no response. A read produces one response word. While a response is waiting (`rsp_valid` high and not yet taken with `rsp_ready`), `req_ready` stays low, so no new request of either kind is accepted.

Top module: `spi_prog_shifter`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_mosi` is 0. The command, length, transmit and receive registers all read 0.
- R2: A write to the command register (address 0x00) with bit 2 set starts an exchange if the engine is idle and the length register is not zero. Bit 2 of the command register then reads 1 until the exchange ends, and reads 0 afterwards.
- R3: The transmit bank sits at address 0x10+i for i = 0..5. Transmit byte 5 goes out first, then the bytes at descending indices, each byte MSB-first.
- R4: Bit positions after the 48 bits of the transmit bank go out as 0.
- R5: The receive bank sits at address 0x20+i for i = 0..9. The bank is cleared when an exchange starts. After an exchange of N whole bytes, the first byte received is at index N-1 and later bytes are at lower indices. For a bit length L, the received bits form an L-bit number, right-aligned across the bank with byte 0 as the least significant byte.
- R6: The length register (address 0x01) holds the bit count. Each exchange produces exactly that many rising SCK edges, limited to 80. Writing the go bit with a length of 0 starts nothing.
- R7: SPI mode 0 is used. SCK idles low and rises only while chip select is low. MOSI changes only when SCK falls or when chip select falls. MISO is sampled on each rising SCK edge.
- R8: Chip select falls HALF_CYCLES system clocks before the first rising SCK edge and rises HALF_CYCLES clocks after the last falling edge. The busy bit clears only after chip select has risen.
- R9: A write to the command register while an exchange is in progress has no effect. No second exchange follows.
- R10: A read is answered on the next cycle with `rsp_valid`. The response and its data stay unchanged until `rsp_ready` is high. `req_ready` is low while a response is pending.
- R11: A command write with bit 2 clear starts nothing, whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken when high |
| rsp_rdata | output | 8 | Read response data |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a go write that lands while an exchange is running. The port gives no way to pause the engine, so the stimulus issues a new length write and a second go write in back-to-back cycles right after the first go. It then counts chip-select falls and SCK edges until long after the first exchange has ended. Lengths above the bank size and lengths that are not whole bytes are driven from the vector table. A slave model in the bench supplies a known MISO pattern and times the chip-select margins in clock periods.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TRAIL,
    ST_DONE
  } shift_state_t;

  localparam logic [7:0] REG_CMD     = 8'h00;
  localparam logic [7:0] REG_BITS    = 8'h01;
  localparam logic [7:0] REG_TX_BASE = 8'h10;
  localparam logic [7:0] REG_RX_BASE = 8'h20;
  localparam int         GO_BIT      = 2;
endpackage

// File: rtl/spi_prog_tick.sv
module spi_prog_tick #(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_prog_regs.sv
module spi_prog_regs
  import spi_prog_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int CNT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [7:0]              req_addr,
  input  logic [7:0]              req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [7:0]              rsp_rdata,
  input  logic                    busy,
  input  logic [RX_BYTES*8-1:0]   rx_bits,
  output logic [TX_BYTES*8-1:0]   tx_bits,
  output logic [CNT_W-1:0]        bit_count,
  output logic                    go
);
  logic       accept;
  logic [7:0] tx_q [TX_BYTES];
  logic [7:0] rd_mux;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  // go pulse: only when idle, bit set, and a nonzero length is loaded
  assign go = accept && req_write && (req_addr == REG_CMD) &&
              req_wdata[GO_BIT] && !busy && (bit_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_count <= '0;
    end else if (accept && req_write && req_addr == REG_BITS) begin
      bit_count <= CNT_W'(req_wdata);
    end
  end

  for (genvar i = 0; i < TX_BYTES; i++) begin : g_tx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q[i] <= '0;
      end else if (accept && req_write && req_addr == REG_TX_BASE + 8'(i)) begin
        tx_q[i] <= req_wdata;
      end
    end
    assign tx_bits[8*i +: 8] = tx_q[i];
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == REG_CMD) begin
      rd_mux[GO_BIT] = busy;
    end else if (req_addr == REG_BITS) begin
      rd_mux = 8'(bit_count);
    end
    for (int i = 0; i < TX_BYTES; i++) begin
      if (req_addr == REG_TX_BASE + 8'(i)) rd_mux = tx_q[i];
    end
    for (int i = 0; i < RX_BYTES; i++) begin
      if (req_addr == REG_RX_BASE + 8'(i)) rd_mux = rx_bits[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
  import spi_prog_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int CNT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      start_bits,
  input  logic [TX_BYTES*8-1:0] tx_bits,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  sck,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  busy,
  output logic                  run,
  output logic [RX_BYTES*8-1:0] rx_bits
);
  localparam int TXW      = TX_BYTES * 8;
  localparam int RXW      = RX_BYTES * 8;
  localparam int MAX_BITS = RXW;
  localparam int BC_W     = $clog2(MAX_BITS + 1);

  shift_state_t     state_q;
  logic [TXW-1:0]   txsh_q;
  logic [RXW-1:0]   rxsh_q;
  logic [BC_W-1:0]  left_q;
  logic [BC_W-1:0]  want;

  // length clamp to the receive bank size
  always_comb begin
    if (int'(start_bits) > MAX_BITS) want = BC_W'(MAX_BITS);
    else                             want = BC_W'(start_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      left_q  <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            txsh_q  <= tx_bits;
            rxsh_q  <= '0;
            left_q  <= want;
            cs_n    <= 1'b0;
            state_q <= ST_LO;
          end
        end
        ST_LO: begin
          if (tick) begin
            sck     <= 1'b1;
            rxsh_q  <= {rxsh_q[RXW-2:0], miso};
            left_q  <= left_q - 1'b1;
            state_q <= ST_HI;
          end
        end
        ST_HI: begin
          if (tick) begin
            sck <= 1'b0;
            if (left_q == '0) begin
              state_q <= ST_TRAIL;
            end else begin
              txsh_q  <= {txsh_q[TXW-2:0], 1'b0};
              state_q <= ST_LO;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mosi    = (state_q == ST_IDLE) ? 1'b0 : txsh_q[TXW-1];
  assign busy    = (state_q != ST_IDLE);
  assign run     = (state_q == ST_LO) || (state_q == ST_HI) || (state_q == ST_TRAIL);
  assign rx_bits = rxsh_q;
endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter
  import spi_prog_pkg::*;
#(
  parameter int TX_BYTES    = 6,
  parameter int RX_BYTES    = 10,
  parameter int CNT_W       = 8,
  parameter int HALF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic                  eng_busy;
  logic                  eng_run;
  logic                  eng_tick;
  logic                  go;
  logic [CNT_W-1:0]      bit_count;
  logic [TX_BYTES*8-1:0] tx_bits;
  logic [RX_BYTES*8-1:0] rx_bits;

  spi_prog_regs #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .busy(eng_busy), .rx_bits(rx_bits), .tx_bits(tx_bits),
    .bit_count(bit_count), .go(go)
  );

  spi_prog_tick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(eng_run), .tick(eng_tick)
  );

  spi_prog_engine #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(go), .start_bits(bit_count),
    .tx_bits(tx_bits), .tick(eng_tick), .miso(spi_miso),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .busy(eng_busy), .run(eng_run), .rx_bits(rx_bits)
  );
endmodule

// File: rtl/spi_prog_shifter_chk.sv
module spi_prog_shifter_chk #(
  parameter int RX_BYTES = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata
);
  localparam int MAX_BITS = RX_BYTES * 8;

  logic       sck_q;
  logic       cs_q;
  logic [7:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      rises <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_q && !cs_n) rises <= '0;
      else if (sck && !sck_q) rises <= rises + 1'b1;
      if (cs_n && !cs_q) begin
        assert_bits_clamped_R6: assert (int'(rises) <= MAX_BITS)
          else $error("R6: %0d rising edges in one exchange", rises);
      end
    end
  end

  assert_sck_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !cs_n);

  assert_sck_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_mosi_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$fell(sck)) |-> $stable(mosi));

  assert_busy_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && $past(cs_n)));

  assert_cs_implies_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_no_req_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind spi_prog_shifter spi_prog_shifter_chk #(.RX_BYTES(RX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .busy(eng_busy), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/spi_prog_shifter_test.sv
`timescale 1ns/1ps
module spi_prog_shifter_test;
  import spi_prog_pkg::*;

  localparam int HALF = 2;
  localparam int PER  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  spi_prog_shifter #(.HALF_CYCLES(HALF)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // slave model
  logic [79:0] rep_cur = '0;
  logic [79:0] cap = '0;
  int  edges = 0;
  int  sl_idx = 0;
  int  cs_falls = 0;
  time t_csfall, t_rise1, t_fall, t_csrise;

  function automatic logic rep_bit(int k);
    return (k < 80) ? rep_cur[79-k] : 1'b0;
  endfunction

  initial forever begin
    @(negedge spi_cs_n);
    t_csfall = $time; cs_falls++; edges = 0; cap = '0; sl_idx = 0;
    spi_miso = rep_bit(0);
  end
  initial forever begin
    @(posedge spi_sck);
    if (edges == 0) t_rise1 = $time;
    cap = {cap[78:0], spi_mosi};
    edges++;
  end
  initial forever begin
    @(negedge spi_sck);
    t_fall = $time; sl_idx++;
    spi_miso = rep_bit(sl_idx);
  end
  initial forever begin
    @(posedge spi_cs_n);
    t_csrise = $time;
  end

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 8'hxx;
  endtask

  task automatic wait_idle(output bit ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      rd(REG_CMD, v);
      if (v[GO_BIT] == 1'b0) begin ok = 1'b1; break; end
    end
  endtask

  // vector: {length bits, tx bank (byte5..byte0), slave reply MSB-first}
  localparam logic [135:0] VEC [5] = '{
    {8'd80,  48'hFFFFFFFFFFFF, 80'h5A5A_C3C3_0F0F_9696_A5A5},
    {8'd8,   48'hA50000000000, 80'h3C00_0000_0000_0000_0000},
    {8'd48,  48'h0123456789AB, 80'hF0E1_D2C3_B4A5_0000_0000},
    {8'd200, 48'h800000000001, 80'h0123_4567_89AB_CDEF_0123},
    {8'd12,  48'hC35000000000, 80'hABC0_0000_0000_0000_0000}
  };

  task automatic run_vec(input int idx);
    logic [7:0]  cnt;
    logic [47:0] tx;
    logic [79:0] rep, exp_m, exp_r, got_r;
    logic [7:0]  v;
    int eff;
    bit ok;
    cnt = VEC[idx][135:128]; tx = VEC[idx][127:80]; rep = VEC[idx][79:0];
    eff = (int'(cnt) > 80) ? 80 : int'(cnt);
    exp_m = '0; exp_r = '0;
    for (int k = 0; k < eff; k++) begin
      exp_m = {exp_m[78:0], (k < 48) ? tx[47-k] : 1'b0};
      exp_r = {exp_r[78:0], rep[79-k]};
    end
    rep_cur = rep;
    for (int i = 0; i < 6; i++) wr(REG_TX_BASE + 8'(i), tx[8*i +: 8]);
    wr(REG_BITS, cnt);
    wr(REG_CMD, 8'h04);
    rd(REG_CMD, v);
    check(v[GO_BIT] == 1'b1, $sformatf("R2 busy set vec%0d", idx), 80'(v), 80'h4);
    wait_idle(ok);
    check(ok, $sformatf("R2 busy clears vec%0d", idx), 80'(ok), 80'h1);
    check(edges == eff, $sformatf("R6 edge count vec%0d", idx), 80'(edges), 80'(eff));
    check(cap == exp_m, $sformatf("R3 R4 mosi stream vec%0d", idx), cap, exp_m);
    got_r = '0;
    for (int i = 0; i < 10; i++) begin
      rd(REG_RX_BASE + 8'(i), v);
      got_r[8*i +: 8] = v;
    end
    check(got_r == exp_r, $sformatf("R5 rx bank vec%0d", idx), got_r, exp_r);
    check((t_rise1 - t_csfall) == HALF*PER && (t_csrise - t_fall) == HALF*PER,
          $sformatf("R8 cs margins vec%0d", idx),
          80'(t_rise1 - t_csfall), 80'(HALF*PER));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int f0;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 pins",
          80'({spi_cs_n, spi_sck, spi_mosi}), 80'b100);
    rd(REG_CMD, v);  check(v == 8'h00, "R1 cmd", 80'(v), 80'h0);
    rd(REG_BITS, v); check(v == 8'h00, "R1 length", 80'(v), 80'h0);
    rd(REG_TX_BASE + 8'd5, v); check(v == 8'h00, "R1 tx5", 80'(v), 80'h0);
    rd(REG_RX_BASE, v); check(v == 8'h00, "R1 rx0", 80'(v), 80'h0);

    // vector walk (80-bit before 8-bit shows R5 clearing)
    for (int i = 0; i < 5; i++) run_vec(i);

    // R6 zero length starts nothing
    f0 = cs_falls;
    wr(REG_BITS, 8'd0);
    wr(REG_CMD, 8'h04);
    rd(REG_CMD, v);
    check(v[GO_BIT] == 1'b0, "R6 zero length busy", 80'(v), 80'h0);
    repeat (20) @(negedge clk);
    check(cs_falls == f0, "R6 zero length no cs", 80'(cs_falls), 80'(f0));

    // R11 go bit clear
    wr(REG_BITS, 8'd8);
    wr(REG_CMD, 8'hFB);
    repeat (20) @(negedge clk);
    check(cs_falls == f0 && spi_cs_n == 1'b1, "R11 other bits no start",
          80'(cs_falls), 80'(f0));

    // R9 go while busy ignored
    rep_cur = '0;
    wr(REG_BITS, 8'd16);
    wr(REG_CMD, 8'h04);
    wr(REG_BITS, 8'd8);
    wr(REG_CMD, 8'h04);
    wait_idle(ok);
    repeat (60) @(negedge clk);
    check(cs_falls == f0 + 1, "R9 single exchange", 80'(cs_falls), 80'(f0 + 1));
    check(edges == 16, "R9 length kept", 80'(edges), 80'd16);

    // R10 response held under back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = REG_BITS;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && !req_ready && rsp_rdata == 8'd8, "R10 response issued",
          80'({rsp_valid, req_ready, rsp_rdata}), 80'({1'b1, 1'b0, 8'd8}));
    repeat (3) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_rdata == 8'd8, "R10 response held",
          80'({rsp_valid, req_ready, rsp_rdata}), 80'({1'b1, 1'b0, 8'd8}));
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10 response taken",
          80'({rsp_valid, req_ready}), 80'b01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule